// File: doc/BRIEF.md
# SPI Flash Transaction Monitor

This block watches the byte stream of a serial NOR-flash link without taking part in it. A bit-level deserializer in front of it delivers one strobe per completed byte, carrying the byte the controller shifted out and the byte the flash shifted back, together with the current chip-select level. The monitor treats the first byte after it has gone idle as a command opcode and counts byte positions from there. It gathers the 24-bit address, identification bytes, status bytes and data-byte counts that belong to that command.

When a command is complete it produces one event record. A command is complete when its last defined byte arrives, or when chip select rises for commands whose length is set by the controller. The record holds a class code, the raw opcode, the address, the captured bytes, the data count and three flags: unknown opcode, truncated transaction and misaligned sector erase. Records leave through a valid/ready handshake backed by a single holding register. A record that arrives while that register is still full is dropped and sets a sticky overflow bit.

The monitor is meant for on-chip tracing or protocol checking in a flash controller subsystem. It never drives the link.

Top module: `spi_flash_txn_mon`

## Requirements
- R1: Opcode classification uses these `evt_class` codes: 0 unknown, 1 write-enable (0x06), 2 write-disable (0x04), 3 identification read (0x9F), 4 status read (0x05), 5 status write (0x01), 6 data read (0x03), 7 fast read (0x0B), 8 sector erase (0x20), 9 block erase (0xD8), 10 chip erase (0x60 or 0xC7), 11 page program (0x02), 12 power-down (0xB9), 13 wake/electronic ID (0xAB), 14 manufacturer/device ID (0x90). Any other opcode produces an event at once with `evt_unknown`=1 and class 0, and the next byte under the same chip select is taken as a new opcode.
- R2: Write-enable, write-disable, both chip-erase codes and power-down produce their event on the opcode byte itself, with all captured fields zero.
- R3: For classes 6, 7, 8, 9 and 11, byte positions 2, 3 and 4 are shifted into `evt_addr` most significant byte first. An incomplete address shows the bytes received right-aligned.
- R4: A complete sector erase (class 8) whose address has any of bits 11..0 set reports `evt_misalign`=1. An aligned sector erase, and any other class, reports 0.
- R5: An identification read ends on byte 4. Its MISO bytes 2, 3 and 4 appear as `evt_mfr_id`, `evt_aux` (memory type) and `evt_dev_id`.
- R6: For classes 3 and 14, `evt_cap` is 1, 2 or 3 for device ID 0x14, 0x15 or 0x16, and 0 for any other ID. For all other classes it is 0.
- R7: A manufacturer/device-ID read ends on byte 6. Bit 0 of MOSI byte 4 selects the reply order: 0 means MISO byte 5 is the manufacturer ID and byte 6 the device ID, 1 means the reverse. The event always reports them in `evt_mfr_id` and `evt_dev_id`.
- R8: A status write ends on byte 2 with that MOSI byte in `evt_aux`. A status read ends on chip-select rise with the last MISO status byte in `evt_aux` and the number of status bytes in `evt_dcount`. A wake/electronic-ID command ends on chip-select rise and reports MISO byte 5 in `evt_aux` if that byte was seen.
- R9: Data read and page program count the bytes from position 5 onward, and fast read counts from position 6 onward (position 5 is a dummy byte). The count is reported in `evt_dcount` when chip select rises.
- R10: If chip select rises before a command has reached its minimum length, the event is produced with `evt_trunc`=1. The minimum is 4 for classes 6 and 11, 5 for class 7, 2 for class 4, 1 for class 13, and the full length for fixed-length commands. Chip select rising while idle produces nothing.
- R11: An event appears on `evt_valid` in the cycle after the clock edge that took the completing byte or chip-select rise. It stays valid with stable contents until `evt_ready` is high.
- R12: An event completed while `evt_valid`=1 and `evt_ready`=0 is dropped, and `evt_overflow` becomes 1 and stays 1 until reset.
- R13: After reset, `evt_valid` and `evt_overflow` are 0 and the monitor is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe for a completed byte pair |
| mosi_byte | input | 8 | Byte sent by the controller |
| miso_byte | input | 8 | Byte returned by the flash |
| cs_n | input | 1 | Chip-select level, active low |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_valid | output | 1 | Event record is present |
| evt_class | output | 4 | Command class code (R1) |
| evt_opcode | output | 8 | Raw opcode byte |
| evt_addr | output | ADDR_W | Assembled address |
| evt_mfr_id | output | 8 | Manufacturer ID |
| evt_aux | output | 8 | Memory type, status byte or electronic ID |
| evt_dev_id | output | 8 | Device ID |
| evt_dcount | output | DCNT_W | Data or status byte count |
| evt_cap | output | 2 | Capacity code from device ID |
| evt_unknown | output | 1 | Unknown opcode flag |
| evt_trunc | output | 1 | Truncated transaction flag |
| evt_misalign | output | 1 | Misaligned sector erase flag |
| evt_overflow | output | 1 | Sticky dropped-event flag |

## Verification
The assertions assume that the deserializer raises `byte_vld` only while `cs_n` is low and for a single cycle per byte. They also assume that `cs_n` stays high for at least one clock between transactions, so every rise is seen at a clock edge. The stimulus drives each byte as a one-cycle strobe with chip select already low, and ends every transaction with a full cycle of chip select high. It releases `evt_ready` only in the overflow scenario, where it holds ready low across two complete commands.

// File: rtl/spi_fmon_pkg.sv
// Package: shared types of the SPI flash transaction monitor.
// Holds the command class codes and the per-opcode length attributes.
package spi_fmon_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [3:0] {
        FC_UNKNOWN     = 4'd0,
        FC_WR_EN       = 4'd1,
        FC_WR_DIS      = 4'd2,
        FC_ID_READ     = 4'd3,
        FC_STAT_READ   = 4'd4,
        FC_STAT_WRITE  = 4'd5,
        FC_DATA_READ   = 4'd6,
        FC_FAST_READ   = 4'd7,
        FC_SECT_ERASE  = 4'd8,
        FC_BLK_ERASE   = 4'd9,
        FC_CHIP_ERASE  = 4'd10,
        FC_PAGE_PROG   = 4'd11,
        FC_POWER_DOWN  = 4'd12,
        FC_WAKE_ID     = 4'd13,
        FC_MFR_DEV_ID  = 4'd14
    } fcls_t;

    // done_len: position of the final byte (0 = ends on chip-select rise)
    // min_len : positions needed before a chip-select rise is not a truncation
    typedef struct packed {
        logic [LEN_W-1:0] done_len;
        logic [LEN_W-1:0] min_len;
        logic             has_addr;
    } fattr_t;

endpackage

// File: rtl/spi_fmon_classify.sv
// Module: opcode classifier.
// Maps an opcode byte to its class and length attributes. Purely combinational.
// Assumes addresses span ADDR_BYTES bytes starting at byte position 2.
module spi_fmon_classify
    import spi_fmon_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic [7:0] opcode,
    output fcls_t      cls,
    output fattr_t     attr
);
    localparam logic [LEN_W-1:0] ADDR_END = LEN_W'(1 + ADDR_BYTES);
    localparam logic [LEN_W-1:0] FAST_MIN = LEN_W'(2 + ADDR_BYTES);

    // Decode the opcode into a class and its length rules.
    always_comb begin
        cls  = FC_UNKNOWN;
        attr = '{done_len: LEN_W'(1), min_len: LEN_W'(1), has_addr: 1'b0};
        unique case (opcode)
            8'h06: cls = FC_WR_EN;
            8'h04: cls = FC_WR_DIS;
            8'h60,
            8'hC7: cls = FC_CHIP_ERASE;
            8'hB9: cls = FC_POWER_DOWN;
            8'h9F: begin
                cls  = FC_ID_READ;
                attr = '{done_len: LEN_W'(4), min_len: LEN_W'(4), has_addr: 1'b0};
            end
            8'h05: begin
                cls  = FC_STAT_READ;
                attr = '{done_len: '0, min_len: LEN_W'(2), has_addr: 1'b0};
            end
            8'h01: begin
                cls  = FC_STAT_WRITE;
                attr = '{done_len: LEN_W'(2), min_len: LEN_W'(2), has_addr: 1'b0};
            end
            8'h03: begin
                cls  = FC_DATA_READ;
                attr = '{done_len: '0, min_len: ADDR_END, has_addr: 1'b1};
            end
            8'h0B: begin
                cls  = FC_FAST_READ;
                attr = '{done_len: '0, min_len: FAST_MIN, has_addr: 1'b1};
            end
            8'h02: begin
                cls  = FC_PAGE_PROG;
                attr = '{done_len: '0, min_len: ADDR_END, has_addr: 1'b1};
            end
            8'h20: begin
                cls  = FC_SECT_ERASE;
                attr = '{done_len: ADDR_END, min_len: ADDR_END, has_addr: 1'b1};
            end
            8'hD8: begin
                cls  = FC_BLK_ERASE;
                attr = '{done_len: ADDR_END, min_len: ADDR_END, has_addr: 1'b1};
            end
            8'hAB: begin
                cls  = FC_WAKE_ID;
                attr = '{done_len: '0, min_len: LEN_W'(1), has_addr: 1'b0};
            end
            8'h90: begin
                cls  = FC_MFR_DEV_ID;
                attr = '{done_len: LEN_W'(6), min_len: LEN_W'(6), has_addr: 1'b0};
            end
            default: cls = FC_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/spi_fmon_tracker.sv
// Module: per-transaction tracker.
// Steps the byte position, captures address, ID, status and data-count
// fields, and raises ev_fire with a complete record in the same cycle as
// the completing byte or chip-select rise. Assumes byte_vld only with cs_n low;
// a strobe seen with cs_n high is ignored.
module spi_fmon_tracker
    import spi_fmon_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DCNT_W     = 16,
    parameter int ALIGN_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        mosi_byte,
    input  logic [7:0]        miso_byte,
    input  logic              cs_n,
    output logic              ev_fire,
    output fcls_t             ev_cls,
    output logic [7:0]        ev_opc,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [7:0]        ev_mfr,
    output logic [7:0]        ev_aux,
    output logic [7:0]        ev_dev,
    output logic [DCNT_W-1:0] ev_dcnt,
    output logic [1:0]        ev_cap,
    output logic              ev_unk,
    output logic              ev_trunc,
    output logic              ev_mis
);
    localparam int               ADDR_BYTES = ADDR_W / 8;
    localparam logic [LEN_W-1:0] ADDR_END   = LEN_W'(1 + ADDR_BYTES);
    localparam logic [LEN_W-1:0] DATA_POS   = LEN_W'(2 + ADDR_BYTES);
    localparam logic [LEN_W-1:0] FDATA_POS  = LEN_W'(3 + ADDR_BYTES);
    localparam logic [LEN_W-1:0] POS_MAX    = '1;

    fcls_t              new_cls, cls_q, cls_n;
    fattr_t             new_attr, attr_q, attr_n;
    logic               active_q, active_n;
    logic [7:0]         opc_q, opc_n;
    logic [LEN_W-1:0]   cnt_q, cnt_n, pos;
    logic [ADDR_W-1:0]  addr_q, addr_n;
    logic [7:0]         mfr_q, mfr_n, aux_q, aux_n, dev_q, dev_n;
    logic [DCNT_W-1:0]  dcnt_q, dcnt_n, dcnt_inc;
    logic               order_q, order_n;
    logic               trunc;

    spi_fmon_classify #(.ADDR_BYTES(ADDR_BYTES)) u_classify (
        .opcode (mosi_byte),
        .cls    (new_cls),
        .attr   (new_attr)
    );

    // Saturating increment of the data/status byte count.
    assign dcnt_inc = (dcnt_q == '1) ? dcnt_q : dcnt_q + 1'b1;
    // Next byte position, saturating.
    assign pos      = (cnt_q == POS_MAX) ? cnt_q : cnt_q + 1'b1;

    // Next-state and event decision for the current byte or chip-select rise.
    always_comb begin
        active_n = active_q;
        cls_n    = cls_q;
        attr_n   = attr_q;
        opc_n    = opc_q;
        cnt_n    = cnt_q;
        addr_n   = addr_q;
        mfr_n    = mfr_q;
        aux_n    = aux_q;
        dev_n    = dev_q;
        dcnt_n   = dcnt_q;
        order_n  = order_q;
        ev_fire  = 1'b0;
        trunc    = 1'b0;
        if (cs_n) begin
            if (active_q) begin
                ev_fire  = 1'b1;
                trunc    = (cnt_q < attr_q.min_len);
                active_n = 1'b0;
            end
        end else if (byte_vld) begin
            if (!active_q) begin
                opc_n   = mosi_byte;
                cls_n   = new_cls;
                attr_n  = new_attr;
                cnt_n   = LEN_W'(1);
                addr_n  = '0;
                mfr_n   = '0;
                aux_n   = '0;
                dev_n   = '0;
                dcnt_n  = '0;
                order_n = 1'b0;
                if (new_cls == FC_UNKNOWN || new_attr.done_len == LEN_W'(1)) begin
                    ev_fire = 1'b1;
                end else begin
                    active_n = 1'b1;
                end
            end else begin
                cnt_n = pos;
                if (attr_q.has_addr && pos >= LEN_W'(2) && pos <= ADDR_END) begin
                    addr_n = {addr_q[ADDR_W-9:0], mosi_byte};
                end
                unique case (cls_q)
                    FC_ID_READ: begin
                        if (pos == LEN_W'(2)) mfr_n = miso_byte;
                        if (pos == LEN_W'(3)) aux_n = miso_byte;
                        if (pos == LEN_W'(4)) dev_n = miso_byte;
                    end
                    FC_STAT_READ: begin
                        aux_n  = miso_byte;
                        dcnt_n = dcnt_inc;
                    end
                    FC_STAT_WRITE: begin
                        if (pos == LEN_W'(2)) aux_n = mosi_byte;
                    end
                    FC_DATA_READ, FC_PAGE_PROG: begin
                        if (pos >= DATA_POS) dcnt_n = dcnt_inc;
                    end
                    FC_FAST_READ: begin
                        if (pos >= FDATA_POS) dcnt_n = dcnt_inc;
                    end
                    FC_WAKE_ID: begin
                        if (pos == DATA_POS) aux_n = miso_byte;
                    end
                    FC_MFR_DEV_ID: begin
                        if (pos == LEN_W'(4)) order_n = mosi_byte[0];
                        if (pos == LEN_W'(5)) begin
                            if (order_q) dev_n = miso_byte;
                            else         mfr_n = miso_byte;
                        end
                        if (pos == LEN_W'(6)) begin
                            if (order_q) mfr_n = miso_byte;
                            else         dev_n = miso_byte;
                        end
                    end
                    default: ;
                endcase
                if (attr_q.done_len != '0 && pos == attr_q.done_len) begin
                    ev_fire  = 1'b1;
                    active_n = 1'b0;
                end
            end
        end
    end

    // Event record fields, taken from the post-update values.
    always_comb begin
        ev_cls   = cls_n;
        ev_opc   = opc_n;
        ev_addr  = addr_n;
        ev_mfr   = mfr_n;
        ev_aux   = aux_n;
        ev_dev   = dev_n;
        ev_dcnt  = dcnt_n;
        ev_trunc = trunc;
        ev_unk   = (cls_n == FC_UNKNOWN);
        ev_mis   = (cls_n == FC_SECT_ERASE) && !trunc && (|addr_n[ALIGN_BITS-1:0]);
        ev_cap   = 2'd0;
        if (cls_n == FC_ID_READ || cls_n == FC_MFR_DEV_ID) begin
            unique case (dev_n)
                8'h14:   ev_cap = 2'd1;
                8'h15:   ev_cap = 2'd2;
                8'h16:   ev_cap = 2'd3;
                default: ev_cap = 2'd0;
            endcase
        end
    end

    // Transaction state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cls_q    <= FC_UNKNOWN;
            attr_q   <= '0;
            opc_q    <= '0;
            cnt_q    <= '0;
            addr_q   <= '0;
            mfr_q    <= '0;
            aux_q    <= '0;
            dev_q    <= '0;
            dcnt_q   <= '0;
            order_q  <= 1'b0;
        end else begin
            active_q <= active_n;
            cls_q    <= cls_n;
            attr_q   <= attr_n;
            opc_q    <= opc_n;
            cnt_q    <= cnt_n;
            addr_q   <= addr_n;
            mfr_q    <= mfr_n;
            aux_q    <= aux_n;
            dev_q    <= dev_n;
            dcnt_q   <= dcnt_n;
            order_q  <= order_n;
        end
    end

endmodule

// File: rtl/spi_fmon_evq.sv
// Module: single-entry event holding register.
// Loads a pushed record when empty or when the held one leaves in the same
// cycle; otherwise drops the new record and sets a sticky overflow bit.
module spi_fmon_evq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout,
    output logic         ovf
);
    // Hold, replace or release the record and track drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
            ovf   <= 1'b0;
        end else if (push && (!valid || ready)) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (push) begin
            ovf   <= 1'b1;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_flash_txn_mon.sv
// Module: SPI flash transaction monitor (top).
// Passive observer of a byte-level SPI flash link: classifies commands,
// captures their fields and emits one event record per command through a
// valid/ready output. Assumes bytes arrive only while cs_n is low.
module spi_flash_txn_mon #(
    parameter int ADDR_W     = 24,
    parameter int DCNT_W     = 16,
    parameter int ALIGN_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        mosi_byte,
    input  logic [7:0]        miso_byte,
    input  logic              cs_n,
    input  logic              evt_ready,
    output logic              evt_valid,
    output logic [3:0]        evt_class,
    output logic [7:0]        evt_opcode,
    output logic [ADDR_W-1:0] evt_addr,
    output logic [7:0]        evt_mfr_id,
    output logic [7:0]        evt_aux,
    output logic [7:0]        evt_dev_id,
    output logic [DCNT_W-1:0] evt_dcount,
    output logic [1:0]        evt_cap,
    output logic              evt_unknown,
    output logic              evt_trunc,
    output logic              evt_misalign,
    output logic              evt_overflow
);
    import spi_fmon_pkg::*;

    localparam int REC_W = 4 + 8 + ADDR_W + 24 + DCNT_W + 2 + 3;

    logic              ev_fire, ev_unk, ev_trunc, ev_mis;
    fcls_t             ev_cls;
    logic [7:0]        ev_opc, ev_mfr, ev_aux, ev_dev;
    logic [ADDR_W-1:0] ev_addr;
    logic [DCNT_W-1:0] ev_dcnt;
    logic [1:0]        ev_cap;
    logic [REC_W-1:0]  rec_in, rec_out;

    spi_fmon_tracker #(
        .ADDR_W     (ADDR_W),
        .DCNT_W     (DCNT_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .mosi_byte (mosi_byte),
        .miso_byte (miso_byte),
        .cs_n      (cs_n),
        .ev_fire   (ev_fire),
        .ev_cls    (ev_cls),
        .ev_opc    (ev_opc),
        .ev_addr   (ev_addr),
        .ev_mfr    (ev_mfr),
        .ev_aux    (ev_aux),
        .ev_dev    (ev_dev),
        .ev_dcnt   (ev_dcnt),
        .ev_cap    (ev_cap),
        .ev_unk    (ev_unk),
        .ev_trunc  (ev_trunc),
        .ev_mis    (ev_mis)
    );

    // Pack the record for the holding register.
    assign rec_in = {ev_cls, ev_opc, ev_addr, ev_mfr, ev_aux, ev_dev,
                     ev_dcnt, ev_cap, ev_unk, ev_trunc, ev_mis};

    spi_fmon_evq #(.W(REC_W)) u_evq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ev_fire),
        .din   (rec_in),
        .ready (evt_ready),
        .valid (evt_valid),
        .dout  (rec_out),
        .ovf   (evt_overflow)
    );

    // Unpack the held record onto the output ports.
    assign {evt_class, evt_opcode, evt_addr, evt_mfr_id, evt_aux, evt_dev_id,
            evt_dcount, evt_cap, evt_unknown, evt_trunc, evt_misalign} = rec_out;

endmodule

// File: rtl/spi_fmon_chk.sv
// Module: assertion checker for the SPI flash transaction monitor.
// Observes only top-level ports; attached by the bind statement below.
// Assumes byte_vld is raised only with cs_n low.
module spi_fmon_chk #(
    parameter int ADDR_W     = 24,
    parameter int DCNT_W     = 16,
    parameter int ALIGN_BITS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic              cs_n,
    input logic              evt_ready,
    input logic              evt_valid,
    input logic [3:0]        evt_class,
    input logic [7:0]        evt_opcode,
    input logic [ADDR_W-1:0] evt_addr,
    input logic [DCNT_W-1:0] evt_dcount,
    input logic [1:0]        evt_cap,
    input logic              evt_unknown,
    input logic              evt_trunc,
    input logic              evt_misalign,
    input logic              evt_overflow
);
    // R11: a held event keeps its contents until accepted
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |=> evt_valid && $stable(evt_class) &&
        $stable(evt_opcode) && $stable(evt_addr) && $stable(evt_dcount))
        else $error("R11 event changed while held");

    // R11: a new event only follows a byte strobe or chip select high
    assert_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_valid) |-> $past(byte_vld || cs_n))
        else $error("R11 event without cause");

    // R12: overflow is sticky
    assert_sticky_ovf_R12: assert property (@(posedge clk) disable iff (!rst_n)
        evt_overflow |=> evt_overflow)
        else $error("R12 overflow cleared");

    // R12: overflow only rises while an event is held
    assert_ovf_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_overflow) |-> $past(evt_valid && !evt_ready))
        else $error("R12 overflow without held event");

    // R4: misalignment only on an untruncated sector erase with low bits set
    assert_misalign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_misalign |-> evt_class == 4'd8 && !evt_trunc &&
        (|evt_addr[ALIGN_BITS-1:0]))
        else $error("R4 misalign flag on wrong event");

    // R1: unknown events carry class 0 and are never truncated
    assert_unknown_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_unknown |-> evt_class == 4'd0 && !evt_trunc)
        else $error("R1 unknown event malformed");

    // R6: capacity code only on identification classes
    assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_cap != 2'd0 |-> evt_class == 4'd3 || evt_class == 4'd14)
        else $error("R6 capacity on wrong class");

endmodule

bind spi_flash_txn_mon spi_fmon_chk #(
    .ADDR_W     (ADDR_W),
    .DCNT_W     (DCNT_W),
    .ALIGN_BITS (ALIGN_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .cs_n         (cs_n),
    .evt_ready    (evt_ready),
    .evt_valid    (evt_valid),
    .evt_class    (evt_class),
    .evt_opcode   (evt_opcode),
    .evt_addr     (evt_addr),
    .evt_dcount   (evt_dcount),
    .evt_cap      (evt_cap),
    .evt_unknown  (evt_unknown),
    .evt_trunc    (evt_trunc),
    .evt_misalign (evt_misalign),
    .evt_overflow (evt_overflow)
);

// File: tb/spi_flash_txn_mon_tb_top.sv
// Bench: scoreboard for the SPI flash transaction monitor.
// Driver tasks push expected events into a queue; a monitor process pops and
// compares each event accepted at the output.
module spi_flash_txn_mon_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  mosi_byte = 8'h00;
    logic [7:0]  miso_byte = 8'h00;
    logic        cs_n = 1'b1;
    logic        evt_ready = 1'b1;
    logic        evt_valid;
    logic [3:0]  evt_class;
    logic [7:0]  evt_opcode;
    logic [23:0] evt_addr;
    logic [7:0]  evt_mfr_id, evt_aux, evt_dev_id;
    logic [15:0] evt_dcount;
    logic [1:0]  evt_cap;
    logic        evt_unknown, evt_trunc, evt_misalign, evt_overflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [81:0] rec;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_txn_mon dut_i (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .mosi_byte(mosi_byte),
        .miso_byte(miso_byte), .cs_n(cs_n), .evt_ready(evt_ready),
        .evt_valid(evt_valid), .evt_class(evt_class), .evt_opcode(evt_opcode),
        .evt_addr(evt_addr), .evt_mfr_id(evt_mfr_id), .evt_aux(evt_aux),
        .evt_dev_id(evt_dev_id), .evt_dcount(evt_dcount), .evt_cap(evt_cap),
        .evt_unknown(evt_unknown), .evt_trunc(evt_trunc),
        .evt_misalign(evt_misalign), .evt_overflow(evt_overflow)
    );

    function automatic logic [81:0] pack_rec(
        logic [3:0] cls, logic [7:0] opc, logic [23:0] addr, logic [7:0] mfr,
        logic [7:0] aux, logic [7:0] dev, logic [15:0] dcnt, logic [1:0] cap,
        logic unk, logic trunc, logic mis);
        return {cls, opc, addr, mfr, aux, dev, dcnt, cap, unk, trunc, mis};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [81:0] act, input logic [81:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input string tag, input logic [3:0] cls, input logic [7:0] opc,
        input logic [23:0] addr, input logic [7:0] mfr, input logic [7:0] aux,
        input logic [7:0] dev, input logic [15:0] dcnt, input logic [1:0] cap,
        input logic unk, input logic trunc, input logic mis);
        exp_t e;
        e.rec = pack_rec(cls, opc, addr, mfr, aux, dev, dcnt, cap, unk, trunc, mis);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic xfer(input logic [7:0] mo, input logic [7:0] mi);
        tick();
        cs_n = 1'b0; byte_vld = 1'b1; mosi_byte = mo; miso_byte = mi;
        tick();
        byte_vld = 1'b0;
    endtask

    task automatic cs_end();
        tick();
        cs_n = 1'b1;
        tick();
    endtask

    // Scoreboard monitor: compare each accepted event against the queue head.
    always @(negedge clk) begin
        if (rst_n && evt_valid && evt_ready) begin
            logic [81:0] act;
            act = pack_rec(evt_class, evt_opcode, evt_addr, evt_mfr_id, evt_aux,
                           evt_dev_id, evt_dcount, evt_cap, evt_unknown,
                           evt_trunc, evt_misalign);
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected event", act, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(act === e.rec, e.tag, act, e.rec);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        check(!evt_valid && !evt_overflow, "R13 reset state",
              {80'd0, evt_valid, evt_overflow}, '0);

        // R2 / R11: write-enable completes on its opcode byte
        expect_ev("R2 write-enable", 4'd1, 8'h06, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'h06, 8'h00);
        @(negedge clk);
        check(evt_valid === 1'b1, "R11 event cycle after byte", {81'd0, evt_valid}, 82'd1);
        cs_end();

        // R2: chip erase (both codes), power-down, write-disable
        expect_ev("R2 chip erase C7", 4'd10, 8'hC7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'hC7, 8'h00);
        expect_ev("R2 chip erase 60", 4'd10, 8'h60, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'h60, 8'h00);
        cs_end();
        expect_ev("R2 power-down", 4'd12, 8'hB9, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'hB9, 8'h00);
        expect_ev("R2 write-disable", 4'd2, 8'h04, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'h04, 8'h00);
        cs_end();

        // R5 / R6: identification read, known and unknown device
        expect_ev("R5 R6 id read 0x15", 4'd3, 8'h9F, 0, 8'hC2, 8'h20, 8'h15, 0, 2'd2, 0, 0, 0);
        xfer(8'h9F, 8'h00); xfer(8'h00, 8'hC2); xfer(8'h00, 8'h20); xfer(8'h00, 8'h15);
        cs_end();
        expect_ev("R6 id read unknown dev", 4'd3, 8'h9F, 0, 8'hC2, 8'h20, 8'h17, 0, 2'd0, 0, 0, 0);
        xfer(8'h9F, 8'h00); xfer(8'h00, 8'hC2); xfer(8'h00, 8'h20); xfer(8'h00, 8'h17);
        cs_end();

        // R3 / R9: data read with three data bytes
        expect_ev("R3 R9 data read", 4'd6, 8'h03, 24'h123456, 0, 0, 0, 16'd3, 0, 0, 0, 0);
        xfer(8'h03, 8'h00); xfer(8'h12, 8'h00); xfer(8'h34, 8'h00); xfer(8'h56, 8'h00);
        xfer(8'h00, 8'hA1); xfer(8'h00, 8'hA2); xfer(8'h00, 8'hA3);
        cs_end();

        // R4: aligned and misaligned sector erase, block erase never flagged
        expect_ev("R4 sector erase aligned", 4'd8, 8'h20, 24'h001000, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'h20, 8'h00); xfer(8'h00, 8'h00); xfer(8'h10, 8'h00); xfer(8'h00, 8'h00);
        cs_end();
        expect_ev("R4 sector erase misaligned", 4'd8, 8'h20, 24'h012345, 0, 0, 0, 0, 0, 0, 0, 1);
        xfer(8'h20, 8'h00); xfer(8'h01, 8'h00); xfer(8'h23, 8'h00); xfer(8'h45, 8'h00);
        cs_end();
        expect_ev("R4 block erase no flag", 4'd9, 8'hD8, 24'h012345, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'hD8, 8'h00); xfer(8'h01, 8'h00); xfer(8'h23, 8'h00); xfer(8'h45, 8'h00);
        cs_end();

        // R7: manufacturer/device ID in both reply orders
        expect_ev("R7 order device first", 4'd14, 8'h90, 0, 8'hC2, 0, 8'h16, 0, 2'd3, 0, 0, 0);
        xfer(8'h90, 8'h00); xfer(8'h00, 8'h00); xfer(8'h00, 8'h00); xfer(8'h01, 8'h00);
        xfer(8'h00, 8'h16); xfer(8'h00, 8'hC2);
        cs_end();
        expect_ev("R7 order manufacturer first", 4'd14, 8'h90, 0, 8'hC2, 0, 8'h14, 0, 2'd1, 0, 0, 0);
        xfer(8'h90, 8'h00); xfer(8'h00, 8'h00); xfer(8'h00, 8'h00); xfer(8'h00, 8'h00);
        xfer(8'h00, 8'hC2); xfer(8'h00, 8'h14);
        cs_end();

        // R1: unknown opcode, then next byte under same select is an opcode
        expect_ev("R1 unknown opcode", 4'd0, 8'hFF, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        xfer(8'hFF, 8'h00);
        expect_ev("R1 opcode after unknown", 4'd1, 8'h06, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'h06, 8'h00);
        cs_end();

        // R10: truncated data read and truncated ID read
        expect_ev("R10 R3 truncated read", 4'd6, 8'h03, 24'h00AABB, 0, 0, 0, 0, 0, 0, 1, 0);
        xfer(8'h03, 8'h00); xfer(8'hAA, 8'h00); xfer(8'hBB, 8'h00);
        cs_end();
        expect_ev("R10 truncated id read", 4'd14, 8'h90, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        xfer(8'h90, 8'h00); xfer(8'h00, 8'h00); xfer(8'h00, 8'h00);
        cs_end();

        // R8: status read, status write, wake with and without ID
        expect_ev("R8 status read", 4'd4, 8'h05, 0, 0, 8'h00, 0, 16'd3, 0, 0, 0, 0);
        xfer(8'h05, 8'h00); xfer(8'h00, 8'h03); xfer(8'h00, 8'h02); xfer(8'h00, 8'h00);
        cs_end();
        expect_ev("R8 status write", 4'd5, 8'h01, 0, 0, 8'h3C, 0, 0, 0, 0, 0, 0);
        xfer(8'h01, 8'h00); xfer(8'h3C, 8'h00);
        cs_end();
        expect_ev("R8 R10 wake only", 4'd13, 8'hAB, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'hAB, 8'h00);
        cs_end();
        expect_ev("R8 wake with id", 4'd13, 8'hAB, 0, 0, 8'h14, 0, 0, 0, 0, 0, 0);
        xfer(8'hAB, 8'h00); xfer(8'h00, 8'h00); xfer(8'h00, 8'h00); xfer(8'h00, 8'h00);
        xfer(8'h00, 8'h14);
        cs_end();

        // R9: fast read skips the dummy byte; page program counts data
        expect_ev("R9 fast read", 4'd7, 8'h0B, 24'h000100, 0, 0, 0, 16'd2, 0, 0, 0, 0);
        xfer(8'h0B, 8'h00); xfer(8'h00, 8'h00); xfer(8'h01, 8'h00); xfer(8'h00, 8'h00);
        xfer(8'h00, 8'h00); xfer(8'h00, 8'h55); xfer(8'h00, 8'h66);
        cs_end();
        expect_ev("R9 page program", 4'd11, 8'h02, 24'h000200, 0, 0, 0, 16'd4, 0, 0, 0, 0);
        xfer(8'h02, 8'h00); xfer(8'h00, 8'h00); xfer(8'h02, 8'h00); xfer(8'h00, 8'h00);
        for (int i = 0; i < 4; i++) xfer(8'(i), 8'h00);
        cs_end();

        // R10: chip select toggling while idle gives no event
        cs_end();
        cs_end();

        // R12: overflow drops the second event and sticks
        tick();
        evt_ready = 1'b0;
        expect_ev("R12 held event kept", 4'd1, 8'h06, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xfer(8'h06, 8'h00);
        xfer(8'h04, 8'h00);
        cs_end();
        @(negedge clk);
        check(evt_overflow === 1'b1 && evt_valid === 1'b1 && evt_class === 4'd1,
              "R12 overflow set with first event held",
              {78'd0, evt_overflow, evt_valid, evt_class[1:0]}, {78'd0, 1'b1, 1'b1, 2'd1});
        tick();
        evt_ready = 1'b1;
        repeat (4) tick();
        @(negedge clk);
        check(evt_overflow === 1'b1 && evt_valid === 1'b0, "R12 overflow sticky, dropped event gone",
              {80'd0, evt_overflow, evt_valid}, {80'd0, 1'b1, 1'b0});

        repeat (4) tick();
        check(exp_q.size() == 0, "R11 all expected events delivered",
              82'(exp_q.size()), 82'd0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule